// File: doc/BRIEF.md
# Fractional UART Baud-Rate Generator

This block turns a system clock into the two timing strobes a UART needs. It emits an oversample strobe sixteen times per bit and a bit strobe once per bit. The spacing between oversample strobes is set by a divider equal to the clock frequency over sixteen times the wanted baud rate. The divider has a 12-bit whole part (the mantissa) and a 4-bit fractional part counted in sixteenths. Software works the divider out beforehand and loads it through two byte-wide configuration registers.

The low byte holds mantissa bits 7:0. The high byte holds mantissa bits 11:8 in its upper nibble and the fraction in its lower nibble. The fraction is handled by a 4-bit phase accumulator: each oversample period lasts the mantissa count, plus one cycle whenever adding the fraction to the accumulator wraps it past fifteen. A new divider value is picked up only when one period ends and the next begins, so no period is ever cut short. A mantissa of zero parks the generator with no strobes.

Top module: `frac_baud_gen`

## Requirements
- R1: A strobe on `cfg_lo_we` loads `cfg_lo_data` into mantissa bits 7:0. A strobe on `cfg_hi_we` loads `cfg_hi_data[7:4]` into mantissa bits 11:8 and `cfg_hi_data[3:0]` into the fraction. Without a strobe, neither register changes.
- R2: After reset both configuration registers hold 0x00, and `os_tick` and `bit_tick` stay low.
- R3: With fraction 0 and mantissa M, consecutive `os_tick` pulses are exactly M cycles apart, and each pulse is one cycle wide.
- R4: With fraction F, each period adds F to a 4-bit accumulator. A period lasts M+1 cycles when that addition carries out of the accumulator, and M cycles otherwise. The accumulator restarts at zero whenever `enable` is low.
- R5: While the mantissa is zero, no strobes are produced. Once a nonzero mantissa is written, strobes resume by themselves.
- R6: `bit_tick` is high only together with `os_tick`, on every sixteenth `os_tick` counted from the cycle `enable` rises.
- R7: While `enable` is low, both strobes are low in that same cycle. After `enable` rises, the first `os_tick` comes one full period after the first clock edge that samples `enable` high.
- R8: A configuration write made during a period, including one in the very cycle an `os_tick` is high, does not change the period already under way. It takes effect at the next period boundary.
- R9: Mantissa 1 with fraction 0 gives an `os_tick` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_lo_data | input | 8 | Write data for the low divider byte |
| cfg_lo_we | input | 1 | Write strobe for the low divider byte |
| cfg_hi_data | input | 8 | Write data for the high divider byte (upper mantissa nibble, fraction nibble) |
| cfg_hi_we | input | 1 | Write strobe for the high divider byte |
| enable | input | 1 | Runs the generator; low clears the count, the accumulator and the bit phase |
| os_tick | output | 1 | One-cycle oversample strobe |
| bit_tick | output | 1 | One-cycle strobe on every sixteenth oversample strobe |

## Verification
Two things can land in the same cycle: a register write and a period reload. When `os_tick` is high, the bench writes a new mantissa in that very cycle. It then requires the next period to keep the old length and the one after it to take the new length. This proves the reload edge samples the register contents from before the write. A second case writes a zero mantissa at a tick. The bench expects exactly one more period at the old length and then silence. Writing a nonzero value again must restart the strobes after the one-edge register delay plus a full period.

// File: rtl/fbg_pkg.sv
// Package: default geometry shared by the baud generator and its checker.
// Assumes the high byte splits into an upper-mantissa nibble and a fraction.
package fbg_pkg;
    localparam int REG_W_DEF    = 8;   // configuration register width
    localparam int FRAC_W_DEF   = 4;   // fraction bits (sixteenths)
    localparam int OS_RATIO_DEF = 16;  // oversample strobes per bit
endpackage

// File: rtl/fbg_cfg_regs.sv
// Module: fbg_cfg_regs
// Holds the two divider bytes and unpacks them into mantissa and fraction.
// Assumes REG_W > FRAC_W; the high byte's upper bits extend the mantissa.
module fbg_cfg_regs #(
    parameter int REG_W  = 8,
    parameter int FRAC_W = 4,
    localparam int MANT_W = 2 * REG_W - FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  lo_data,
    input  logic              lo_we,
    input  logic [REG_W-1:0]  hi_data,
    input  logic              hi_we,
    output logic [MANT_W-1:0] mant,
    output logic [FRAC_W-1:0] frac
);
    logic [REG_W-1:0] lo_q;
    logic [REG_W-1:0] hi_q;

    // Purpose: capture each byte on its own write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (lo_we) lo_q <= lo_data;
            if (hi_we) hi_q <= hi_data;
        end
    end

    // Purpose: unpack the divider fields from the stored bytes.
    always_comb begin
        mant = {hi_q[REG_W-1:FRAC_W], lo_q};
        frac = hi_q[FRAC_W-1:0];
    end
endmodule

// File: rtl/fbg_divider.sv
// Module: fbg_divider
// Counts down one oversample period at a time. At each period boundary it
// loads mantissa plus the carry of a fractional phase accumulator.
// Assumes mant/frac are sampled only at boundaries; a zero mantissa idles.
module fbg_divider #(
    parameter int MANT_W = 12,
    parameter int FRAC_W = 4,
    localparam int CNT_W = MANT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [MANT_W-1:0] mant,
    input  logic [FRAC_W-1:0] frac,
    output logic              os_tick
);
    logic [CNT_W-1:0]  cnt_q;
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   phase_sum;
    logic [CNT_W-1:0]  next_len;
    logic              boundary;

    // Purpose: next accumulator phase and the length of the next period.
    always_comb begin
        phase_sum = {1'b0, acc_q} + {1'b0, frac};
        next_len  = {1'b0, mant} + CNT_W'(phase_sum[FRAC_W]);
        boundary  = (cnt_q == '0) || (cnt_q == CNT_W'(1));
    end

    // Purpose: down-count the period, reload at the boundary, clear on disable.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt_q <= '0;
            acc_q <= '0;
        end else if (boundary) begin
            if (mant == '0) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= next_len;
                acc_q <= phase_sum[FRAC_W-1:0];
            end
        end else begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Purpose: strobe in the last cycle of every period.
    assign os_tick = enable && (cnt_q == CNT_W'(1));
endmodule

// File: rtl/fbg_bit_counter.sv
// Module: fbg_bit_counter
// Counts oversample strobes and flags the last one of each bit.
// Assumes OS_RATIO >= 2; the phase restarts whenever enable is low.
module fbg_bit_counter #(
    parameter int OS_RATIO = 16,
    localparam int BC_W = $clog2(OS_RATIO)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic os_tick,
    output logic bit_tick
);
    logic [BC_W-1:0] phase_q;
    logic            wrap;

    assign wrap     = (phase_q == BC_W'(OS_RATIO - 1));
    assign bit_tick = os_tick && wrap;

    // Purpose: advance the bit phase on each oversample strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            phase_q <= '0;
        end else if (os_tick) begin
            phase_q <= wrap ? '0 : phase_q + BC_W'(1);
        end
    end
endmodule

// File: rtl/frac_baud_gen.sv
// Module: frac_baud_gen
// Fractional baud-rate generator: two configuration bytes set a mantissa and
// a sixteenths fraction; outputs an oversample strobe and a bit strobe.
// Assumes the divider value is computed by software from clock and baud rate.
module frac_baud_gen #(
    parameter int REG_W    = fbg_pkg::REG_W_DEF,
    parameter int FRAC_W   = fbg_pkg::FRAC_W_DEF,
    parameter int OS_RATIO = fbg_pkg::OS_RATIO_DEF,
    localparam int MANT_W  = 2 * REG_W - FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] cfg_lo_data,
    input  logic             cfg_lo_we,
    input  logic [REG_W-1:0] cfg_hi_data,
    input  logic             cfg_hi_we,
    input  logic             enable,
    output logic             os_tick,
    output logic             bit_tick
);
    logic [MANT_W-1:0] cfg_mant;
    logic [FRAC_W-1:0] cfg_frac;

    fbg_cfg_regs #(.REG_W(REG_W), .FRAC_W(FRAC_W)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .lo_data (cfg_lo_data),
        .lo_we   (cfg_lo_we),
        .hi_data (cfg_hi_data),
        .hi_we   (cfg_hi_we),
        .mant    (cfg_mant),
        .frac    (cfg_frac)
    );

    fbg_divider #(.MANT_W(MANT_W), .FRAC_W(FRAC_W)) i_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .mant    (cfg_mant),
        .frac    (cfg_frac),
        .os_tick (os_tick)
    );

    fbg_bit_counter #(.OS_RATIO(OS_RATIO)) i_bits (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .os_tick  (os_tick),
        .bit_tick (bit_tick)
    );
endmodule

// File: rtl/fbg_checker.sv
// Module: fbg_checker
// Property checks for frac_baud_gen, attached by bind below.
// Assumes the top's internal cfg_mant/cfg_frac nets are visible to the bind.
module fbg_checker #(
    parameter int MANT_W   = 12,
    parameter int FRAC_W   = 4,
    parameter int OS_RATIO = 16,
    localparam int BC_W    = $clog2(OS_RATIO)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              cfg_lo_we,
    input logic              cfg_hi_we,
    input logic [MANT_W-1:0] cfg_mant,
    input logic [FRAC_W-1:0] cfg_frac,
    input logic              os_tick,
    input logic              bit_tick
);
    logic [BC_W-1:0] seen_q;

    // Purpose: independent count of oversample strobes since enable rose.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) seen_q <= '0;
        else if (os_tick)      seen_q <= (seen_q == BC_W'(OS_RATIO - 1)) ? '0 : seen_q + BC_W'(1);
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (cfg_mant == '0 && cfg_frac == '0)); // R2
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_lo_we && !cfg_hi_we) |=> ($stable(cfg_mant) && $stable(cfg_frac))); // R1
    AST_BIT_WITH_OS: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick); // R6
    AST_BIT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> (seen_q == BC_W'(OS_RATIO - 1))); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!os_tick && !bit_tick)); // R7
endmodule

bind frac_baud_gen fbg_checker #(
    .MANT_W(MANT_W), .FRAC_W(FRAC_W), .OS_RATIO(OS_RATIO)
) i_fbg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .cfg_lo_we (cfg_lo_we),
    .cfg_hi_we (cfg_hi_we),
    .cfg_mant  (cfg_mant),
    .cfg_frac  (cfg_frac),
    .os_tick   (os_tick),
    .bit_tick  (bit_tick)
);

// File: tb/test_frac_baud_gen.sv
// Bench: directed scenarios for frac_baud_gen, one task each.
module test_frac_baud_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_lo_data = '0;
    logic       cfg_lo_we = 1'b0;
    logic [7:0] cfg_hi_data = '0;
    logic       cfg_hi_we = 1'b0;
    logic       enable = 1'b0;
    logic       os_tick;
    logic       bit_tick;

    int vectors = 0;
    int errors  = 0;

    always #10 clk = ~clk; // 50 MHz

    frac_baud_gen i_frac_baud_gen (
        .clk(clk), .rst_n(rst_n),
        .cfg_lo_data(cfg_lo_data), .cfg_lo_we(cfg_lo_we),
        .cfg_hi_data(cfg_hi_data), .cfg_hi_we(cfg_hi_we),
        .enable(enable), .os_tick(os_tick), .bit_tick(bit_tick)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle forward; write strobes last a single cycle.
    task automatic step();
        @(negedge clk);
        cfg_lo_we = 1'b0;
        cfg_hi_we = 1'b0;
    endtask

    task automatic set_cfg(input int mant, input int frac);
        cfg_lo_data = mant[7:0];
        cfg_hi_data = {mant[11:8], frac[3:0]};
        cfg_lo_we = 1'b1;
        cfg_hi_we = 1'b1;
    endtask

    // Cycles until the next os_tick, sampled at negedges.
    task automatic wait_tick(output int c);
        c = 0;
        do begin
            step();
            c++;
        end while (!os_tick && c < 6000);
        if (!os_tick) check(1'b0, "watch", c, 0);
    endtask

    task automatic count_ticks(input int n, output int k);
        k = 0;
        for (int i = 0; i < n; i++) begin
            step();
            if (os_tick) k++;
        end
    endtask

    // Restart from disabled and compare every period with the accumulator model.
    task automatic run_periods(input int mant, input int frac, input int n, input string req);
        int acc = 0;
        int c;
        enable = 1'b0;
        step();
        set_cfg(mant, frac);
        step();
        enable = 1'b1;
        for (int i = 1; i <= n; i++) begin
            int s = acc + frac;
            int len = mant + (s >= 16 ? 1 : 0);
            acc = s % 16;
            wait_tick(c);
            check(c == len, req, c, len);
            check(bit_tick == ((i % 16) == 0), "R6", int'(bit_tick), int'((i % 16) == 0));
        end
    endtask

    task automatic t_reset();
        int k;
        check(os_tick == 1'b0 && bit_tick == 1'b0, "R2", int'(os_tick), 0);
        enable = 1'b1;
        count_ticks(40, k);
        check(k == 0, "R2", k, 0);
    endtask

    task automatic t_integer();
        run_periods(5, 0, 20, "R3");
        run_periods(9, 0, 17, "R3");
    endtask

    task automatic t_every_cycle();
        run_periods(1, 0, 34, "R9");
    endtask

    task automatic t_fraction();
        run_periods(3, 8, 20, "R4");
        run_periods(4, 1, 18, "R4");
        run_periods(2, 15, 20, "R4");
        run_periods(1, 8, 10, "R4");
    endtask

    task automatic t_packing();
        run_periods(12'h101, 3, 3, "R1");
        run_periods(12'h230, 13, 3, "R1");
    endtask

    task automatic t_disable();
        int k;
        int c;
        run_periods(3, 8, 1, "R7");
        enable = 1'b0;
        #1;
        check(os_tick == 1'b0, "R7", int'(os_tick), 0);
        count_ticks(30, k);
        check(k == 0, "R7", k, 0);
        enable = 1'b1;
        wait_tick(c);
        check(c == 3, "R7", c, 3); // accumulator restarted at zero
    endtask

    task automatic t_collision();
        int c;
        run_periods(6, 0, 2, "R8");
        cfg_lo_data = 8'd10;
        cfg_lo_we = 1'b1;          // written in the tick cycle
        wait_tick(c);
        check(c == 6, "R8", c, 6);
        wait_tick(c);
        check(c == 10, "R8", c, 10);
        step();
        step();
        cfg_lo_data = 8'd3;
        cfg_lo_we = 1'b1;          // written mid-period
        wait_tick(c);
        check(c == 8, "R8", c, 8);
        wait_tick(c);
        check(c == 3, "R8", c, 3);
    endtask

    task automatic t_zero_mantissa();
        int c;
        int k;
        run_periods(4, 0, 2, "R5");
        set_cfg(0, 0);
        wait_tick(c);
        check(c == 4, "R5", c, 4);
        count_ticks(40, k);
        check(k == 0, "R5", k, 0);
        set_cfg(7, 0);
        wait_tick(c);
        check(c == 8, "R5", c, 8);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_integer();
        t_every_cycle();
        t_fraction();
        t_packing();
        t_disable();
        t_collision();
        t_zero_mantissa();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule